// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register File

This block holds the host-visible registers of a two-channel bus-master DMA controller for ATA-style drives. It sits in a 16-byte I/O window. Each channel owns an 8-byte slice of that window. The slice holds a command byte, a status byte and a 32-bit descriptor-table pointer. The host reaches the window through a plain single-cycle port. That port carries a request, a write enable, an address, an access size and write data. Read data is driven combinationally from the address and the size.

The command byte carries a start/stop bit and a transfer-direction bit. Both go straight to the DMA engine, together with the descriptor pointer. The engine reports back with one-cycle pulses:
- an error pulse sets the error status bit;
- an interrupt pulse sets the interrupt status bit;
- a done pulse clears the active status bit.

The status byte mixes bits of three kinds. Active is read-only to the host. Error and interrupt are write-one-to-clear. Two spare bits are plain read/write. The command/status slice accepts single-byte accesses only. A wider access there is dropped on write and reads back as all ones.

Top module: `bmdma_regfile`

## Requirements
- R1: After reset, the command, status and pointer registers of every channel read zero, and start_o, dir_o and ptr_o are zero.
- R2: Channel c occupies window offsets 8c to 8c+7. Its registers decode on the low three address bits:
  - 0 selects the command byte;
  - 2 selects the status byte;
  - 4 selects the pointer.
  A byte read of the command byte or the status byte returns the register value zero-extended to 32 bits.
- R3: A one-byte read at offset 1 or 3 of a channel returns 0x000000FF.
- R4: The access size is encoded on size_i as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = invalid. At offsets 0..3 of a channel:
  - a read of any size other than 0 returns 0x0000FFFF for size 1 and 0xFFFFFFFF for sizes 2 and 3;
  - a write of any size other than 0 changes nothing.
- R5: A command write stores only bit 0 (start) and bit 3 (direction); every other command bit reads 0. start_o and dir_o show the stored bits.
- R6: Status bit 0 (active) follows the start bit of the last command write: 1 sets it and 0 clears it. An engine done pulse clears active, unless a command write to the same channel happens in the same cycle; in that case the command write decides.
- R7: A byte write to the status byte has these effects:
  - bits 5 and 6 take the written value;
  - bit 0 is unchanged;
  - bits 1 and 2 are cleared where the written bit is 1 and kept where it is 0;
  - bits 3, 4 and 7 read 0.
- R8: An engine error pulse sets status bit 1 and an engine interrupt pulse sets status bit 2. Either pulse wins over a write-one-to-clear of the same bit in the same cycle.
- R9: The pointer register works as follows:
  - a 4-byte write at offset 4 stores the data with bits 1:0 forced to 0;
  - a 4-byte read at offset 4 returns the stored value;
  - any other write to offsets 4..7 is ignored;
  - any other read there returns all ones across the requested width.
- R10: Byte writes to offsets 1 and 3 change no register.
- R11: The channels are independent: an access to one channel, or an engine pulse for one channel, never changes another channel's registers or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 4 | Byte offset inside the window |
| size_i | input | 2 | Access size: 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = invalid |
| wdata_i | input | 32 | Write data, least significant byte at the addressed offset |
| rdata_o | output | 32 | Read data for addr_i and size_i (combinational) |
| eng_err_i | input | 2 | Per-channel error set pulse |
| eng_irq_i | input | 2 | Per-channel interrupt set pulse |
| eng_done_i | input | 2 | Per-channel active clear pulse |
| start_o | output | 2 | Per-channel start bit |
| dir_o | output | 2 | Per-channel direction bit |
| ptr_o | output | 64 | Per-channel descriptor pointer, channel 0 in bits 31:0 |

## Verification
The command byte is swept through all 256 values. This separates the stored start and direction bits from the dropped bits, and shows that active follows start.

The status write rule is swept the same way: all 256 written values are applied with active both set and clear, and with error and interrupt preset. This tells the plain read/write bits apart from the write-one-to-clear bits and from the protected active bit.

Every offset of both channels is read at every size. This covers the 0xFF pad bytes, the all-ones fill of narrow accesses and the pointer alignment. Engine pulses are raised in the same cycle as conflicting host writes to check set-over-clear and command-over-done priority. Channel 1 is loaded with different values while channel 0 is watched for disturbance.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int DW            = 32;
  localparam int CH_BYTES      = 8;
  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 3;
  localparam logic [7:0] CMD_MASK = 8'h09;
  localparam int ST_ACT        = 0;
  localparam int ST_ERR        = 1;
  localparam int ST_IRQ        = 2;
  localparam int ST_USR_LO     = 5;
  localparam int ST_USR_HI     = 6;

  typedef enum logic [1:0] {
    SZ_B1  = 2'd0,
    SZ_B2  = 2'd1,
    SZ_B4  = 2'd2,
    SZ_BAD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RK_CMD  = 2'd0,
    RK_PAD  = 2'd1,
    RK_STAT = 2'd2,
    RK_PTR  = 2'd3
  } reg_kind_e;

  function automatic logic [DW-1:0] size_ones(input logic [1:0] sz);
    case (sz)
      SZ_B1:   return 32'h0000_00FF;
      SZ_B2:   return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
  import bmdma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = $clog2(NCH) + 3,
  localparam int CW = AW - 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [1:0]      size_i,
  output logic [CW-1:0]   ch_o,
  output logic            in_range_o,
  output reg_kind_e       kind_o,
  output logic            byte_ok_o,
  output logic            ptr_ok_o,
  output logic [NCH-1:0]  cmd_we_o,
  output logic [NCH-1:0]  stat_we_o,
  output logic [NCH-1:0]  ptr_we_o
);
  logic wr;

  assign ch_o       = addr_i[AW-1:3];
  assign in_range_o = 32'(ch_o) < NCH;
  assign byte_ok_o  = size_i == SZ_B1;
  assign wr         = req_i && we_i && in_range_o;

  always_comb begin
    if (addr_i[2])               kind_o = RK_PTR;
    else if (addr_i[1:0] == 2'd0) kind_o = RK_CMD;
    else if (addr_i[1:0] == 2'd2) kind_o = RK_STAT;
    else                          kind_o = RK_PAD;
  end

  // pointer only takes aligned dword accesses
  assign ptr_ok_o = (kind_o == RK_PTR) && (size_i == SZ_B4) && (addr_i[1:0] == 2'd0);

  for (genvar c = 0; c < NCH; c++) begin : g_we
    logic hit;
    assign hit          = wr && (32'(ch_o) == c);
    assign cmd_we_o[c]  = hit && byte_ok_o && (kind_o == RK_CMD);
    assign stat_we_o[c] = hit && byte_ok_o && (kind_o == RK_STAT);
    assign ptr_we_o[c]  = hit && ptr_ok_o;
  end

  // R2: one register written per access at most
  p_one_target_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_we_o, stat_we_o, ptr_we_o}));

  // R4: narrow accesses never reach command/status
  p_narrow_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i != SZ_B1 && !addr_i[2]) |-> !(|cmd_we_o) && !(|stat_we_o));

  // R10: pad offsets write nothing
  p_pad_no_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !addr_i[2] && addr_i[0]) |-> !(|{cmd_we_o, stat_we_o, ptr_we_o}));
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic          stat_we_i,
  input  logic          ptr_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          eng_err_i,
  input  logic          eng_irq_i,
  input  logic          eng_done_i,
  output logic [7:0]    cmd_o,
  output logic [7:0]    stat_o,
  output logic [DW-1:0] ptr_o
);
  logic [7:0]    cmd_q;
  logic          act_q, err_q, irq_q;
  logic [1:0]    usr_q;
  logic [DW-1:2] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      act_q <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
      usr_q <= '0;
      ptr_q <= '0;
    end else begin
      if (cmd_we_i) cmd_q <= wdata_i[7:0] & CMD_MASK;

      // host command decides over engine done
      if (cmd_we_i)        act_q <= wdata_i[CMD_START_BIT];
      else if (eng_done_i) act_q <= 1'b0;

      // engine set wins over write-one-to-clear
      if (eng_err_i)                          err_q <= 1'b1;
      else if (stat_we_i && wdata_i[ST_ERR])  err_q <= 1'b0;

      if (eng_irq_i)                          irq_q <= 1'b1;
      else if (stat_we_i && wdata_i[ST_IRQ])  irq_q <= 1'b0;

      if (stat_we_i) usr_q <= wdata_i[ST_USR_HI:ST_USR_LO];
      if (ptr_we_i)  ptr_q <= wdata_i[DW-1:2];
    end
  end

  assign cmd_o  = cmd_q;
  assign stat_o = {1'b0, usr_q, 2'b00, irq_q, err_q, act_q};
  assign ptr_o  = {ptr_q, 2'b00};

  p_start_sets_act_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && wdata_i[CMD_START_BIT]) |=> stat_o[ST_ACT]);

  p_done_clears_act_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done_i && !cmd_we_i) |=> !stat_o[ST_ACT]);

  p_act_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && !cmd_we_i && !eng_done_i) |=> $stable(stat_o[ST_ACT]));

  p_w1c_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && wdata_i[ST_ERR] && !eng_err_i) |=> !stat_o[ST_ERR]);

  p_err_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_err_i |=> stat_o[ST_ERR]);

  p_irq_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_irq_i |=> stat_o[ST_IRQ]);

  p_ptr_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_we_i |=> ptr_o == ($past(wdata_i) & ~32'h3));

  p_ptr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ptr_we_i |=> $stable(ptr_o));
endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
  import bmdma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CW-1:0]            ch_i,
  input  logic                     in_range_i,
  input  reg_kind_e                kind_i,
  input  logic                     byte_ok_i,
  input  logic                     ptr_ok_i,
  input  logic [1:0]               size_i,
  input  logic [NCH-1:0][7:0]      cmd_i,
  input  logic [NCH-1:0][7:0]      stat_i,
  input  logic [NCH-1:0][DW-1:0]   ptr_i,
  output logic [DW-1:0]            rdata_o
);
  always_comb begin
    rdata_o = size_ones(size_i);
    if (in_range_i) begin
      case (kind_i)
        RK_CMD:  if (byte_ok_i) rdata_o = {24'h0, cmd_i[ch_i]};
        RK_STAT: if (byte_ok_i) rdata_o = {24'h0, stat_i[ch_i]};
        RK_PTR:  if (ptr_ok_i)  rdata_o = ptr_i[ch_i];
        default: ;
      endcase
    end
  end

  // R4: narrow reads in command/status area fill with ones
  p_narrow_read_ones_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_range_i && !byte_ok_i && kind_i != RK_PTR) |-> (rdata_o == size_ones(size_i)));

  // R3: pad bytes read 0xFF
  p_pad_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_range_i && byte_ok_i && kind_i == RK_PAD) |-> (rdata_o == 32'h0000_00FF));
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
  import bmdma_pkg::*;
#(
  parameter int NCH = 2,
  localparam int AW = $clog2(NCH) + 3,
  localparam int CW = AW - 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [1:0]         size_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [NCH-1:0]     eng_err_i,
  input  logic [NCH-1:0]     eng_irq_i,
  input  logic [NCH-1:0]     eng_done_i,
  output logic [NCH-1:0]     start_o,
  output logic [NCH-1:0]     dir_o,
  output logic [NCH*DW-1:0]  ptr_o
);
  logic [CW-1:0]           ch;
  logic                    in_range, byte_ok, ptr_ok;
  reg_kind_e               kind;
  logic [NCH-1:0]          cmd_we, stat_we, ptr_we;
  logic [NCH-1:0][7:0]     cmd_v, stat_v;
  logic [NCH-1:0][DW-1:0]  ptr_v;

  bmdma_decode #(.NCH(NCH), .AW(AW)) u_decode (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .size_i,
    .ch_o(ch), .in_range_o(in_range), .kind_o(kind),
    .byte_ok_o(byte_ok), .ptr_ok_o(ptr_ok),
    .cmd_we_o(cmd_we), .stat_we_o(stat_we), .ptr_we_o(ptr_we)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    bmdma_chan u_chan (
      .clk_i, .rst_ni,
      .cmd_we_i(cmd_we[c]), .stat_we_i(stat_we[c]), .ptr_we_i(ptr_we[c]),
      .wdata_i,
      .eng_err_i(eng_err_i[c]), .eng_irq_i(eng_irq_i[c]), .eng_done_i(eng_done_i[c]),
      .cmd_o(cmd_v[c]), .stat_o(stat_v[c]), .ptr_o(ptr_v[c])
    );
    assign start_o[c]            = cmd_v[c][CMD_START_BIT];
    assign dir_o[c]              = cmd_v[c][CMD_DIR_BIT];
    assign ptr_o[c*DW +: DW]     = ptr_v[c];
  end

  bmdma_rdmux #(.NCH(NCH), .CW(CW)) u_rdmux (
    .clk_i, .rst_ni,
    .ch_i(ch), .in_range_i(in_range), .kind_i(kind),
    .byte_ok_i(byte_ok), .ptr_ok_i(ptr_ok), .size_i,
    .cmd_i(cmd_v), .stat_i(stat_v), .ptr_i(ptr_v),
    .rdata_o
  );
endmodule

// File: tb/bmdma_regfile_tb.sv
module bmdma_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  e_err = '0, e_irq = '0, e_done = '0;
  logic [1:0]  start, dir;
  logic [63:0] ptr;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  bmdma_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata),
    .eng_err_i(e_err), .eng_irq_i(e_irq), .eng_done_i(e_done),
    .start_o(start), .dir_o(dir), .ptr_o(ptr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive write (and optional engine pulses) for one cycle
  task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d,
                    input logic [1:0] er = 2'b0, input logic [1:0] ir = 2'b0,
                    input logic [1:0] dn = 2'b0);
    @(negedge clk);
    req = 1; we = 1; addr = a; size = s; wdata = d;
    e_err = er; e_irq = ir; e_done = dn;
    @(negedge clk);
    req = 0; we = 0; e_err = 0; e_irq = 0; e_done = 0;
  endtask

  task automatic eng(input logic [1:0] er, input logic [1:0] ir, input logic [1:0] dn);
    @(negedge clk);
    e_err = er; e_irq = ir; e_done = dn;
    @(negedge clk);
    e_err = 0; e_irq = 0; e_done = 0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [1:0] s,
                    input logic [31:0] exp);
    @(negedge clk);
    req = 0; we = 0; addr = a; size = s;
    #1 chk(tag, {32'h0, rdata}, {32'h0, exp});
  endtask

  function automatic logic [31:0] ones(input logic [1:0] s);
    return (s == 2'd1) ? 32'h0000FFFF : 32'hFFFFFFFF;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int c = 0; c < 2; c++) begin
      rd("R1 cmd",  4'(c*8),     2'd0, 32'h0);
      rd("R1 stat", 4'(c*8 + 2), 2'd0, 32'h0);
      rd("R1 ptr",  4'(c*8 + 4), 2'd2, 32'h0);
    end
    chk("R1 outs", {start, dir, ptr}, 64'h0);

    // R3 pad bytes, R4 narrow reads, R9 odd pointer reads
    for (int c = 0; c < 2; c++) begin
      rd("R3 pad1", 4'(c*8 + 1), 2'd0, 32'hFF);
      rd("R3 pad3", 4'(c*8 + 3), 2'd0, 32'hFF);
      for (int o = 0; o < 4; o++)
        for (int s = 1; s < 4; s++)
          rd("R4 narrow read", 4'(c*8 + o), 2'(s), ones(2'(s)));
      for (int o = 4; o < 8; o++)
        for (int s = 0; s < 4; s++)
          if (!(o == 4 && s == 2))
            rd("R9 odd ptr read", 4'(c*8 + o), 2'(s), (s == 0) ? 32'hFF : ones(2'(s)));
    end

    // R4 narrow writes ignored
    for (int s = 1; s < 4; s++) begin
      wr(4'd0, 2'(s), 32'hFFFF_FFFF);
      wr(4'd2, 2'(s), 32'hFFFF_FFFF);
    end
    rd("R4 cmd after narrow wr",  4'd0, 2'd0, 32'h0);
    rd("R4 stat after narrow wr", 4'd2, 2'd0, 32'h0);

    // R5/R6 command sweep
    for (int v = 0; v < 256; v++) begin
      wr(4'd0, 2'd0, 32'(v));
      rd("R5 cmd value", 4'd0, 2'd0, 32'(v & 8'h09));
      chk("R5 start_o/dir_o", {62'h0, dir[0], start[0]}, {62'h0, 1'(v >> 3), 1'(v)});
      rd("R6 active follows start", 4'd2, 2'd0, 32'(v & 1));
    end

    // R7 status write sweep, active both ways, err/irq preset
    st = 8'h0;
    for (int a = 0; a < 2; a++)
      for (int w = 0; w < 256; w++) begin
        wr(4'd0, 2'd0, 32'(a));
        eng(2'b01, 2'b01, 2'b00);
        st = {1'b0, st[6:5], 4'b0011, 1'(a)} | 8'h06;
        st[1] = 1'b1; st[2] = 1'b1; st[0] = 1'(a);
        wr(4'd2, 2'd0, 32'(w));
        st = (8'(w) & 8'h60) | (st & 8'h01) | (st & ~8'(w) & 8'h06);
        rd("R7 status write rule", 4'd2, 2'd0, {24'h0, st});
      end

    // R8 set wins over simultaneous clear
    wr(4'd2, 2'd0, 32'h06);
    wr(4'd2, 2'd0, 32'h06, 2'b01, 2'b00);
    rd("R8 err set beats clear", 4'd2, 2'd0, 32'h03);
    wr(4'd2, 2'd0, 32'h06, 2'b00, 2'b01);
    rd("R8 irq set beats clear", 4'd2, 2'd0, 32'h05);
    wr(4'd2, 2'd0, 32'h06);

    // R6 done clears active, command write wins over done
    wr(4'd0, 2'd0, 32'h01);
    eng(2'b00, 2'b00, 2'b01);
    rd("R6 done clears active", 4'd2, 2'd0, 32'h00);
    wr(4'd0, 2'd0, 32'h01, 2'b00, 2'b00, 2'b01);
    rd("R6 cmd beats done", 4'd2, 2'd0, 32'h01);

    // R10 pad writes do nothing
    wr(4'd1, 2'd0, 32'hFF);
    wr(4'd3, 2'd0, 32'hFF);
    rd("R10 cmd kept", 4'd0, 2'd0, 32'h01);
    rd("R10 stat kept", 4'd2, 2'd0, 32'h01);

    // R9 pointer
    wr(4'd4, 2'd2, 32'hDEAD_BEEF);
    rd("R9 ptr aligned", 4'd4, 2'd2, 32'hDEAD_BEEC);
    chk("R9 ptr_o", {32'h0, ptr[31:0]}, 64'hDEAD_BEEC);
    wr(4'd4, 2'd0, 32'h0);
    wr(4'd4, 2'd1, 32'h0);
    wr(4'd5, 2'd2, 32'h0);
    rd("R9 narrow ptr write ignored", 4'd4, 2'd2, 32'hDEAD_BEEC);

    // R11 channel 1 independent
    wr(4'd8,  2'd0, 32'h08);
    wr(4'd12, 2'd2, 32'h1234_5677);
    eng(2'b10, 2'b10, 2'b00);
    wr(4'd10, 2'd0, 32'h60);
    rd("R11 ch1 cmd", 4'd8, 2'd0, 32'h08);
    rd("R11 ch1 stat", 4'd10, 2'd0, 32'h66);
    rd("R11 ch1 ptr", 4'd12, 2'd2, 32'h1234_5674);
    chk("R11 ch1 outs", {60'h0, dir, start}, {60'h0, 2'b10, 2'b01});
    rd("R11 ch0 cmd", 4'd0, 2'd0, 32'h01);
    rd("R11 ch0 stat", 4'd2, 2'd0, 32'h01);
    rd("R11 ch0 ptr", 4'd4, 2'd2, 32'hDEAD_BEEC);
    eng(2'b00, 2'b00, 2'b01);
    rd("R11 ch0 done leaves ch1", 4'd10, 2'd0, 32'h66);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule